// File: doc/BRIEF.md
# Floating-Point Status Register and Exception Controller

This block keeps the floating-point control and status word of a small processor core and decides when a floating-point trap is raised. Software reads and writes the word through a special-purpose-register port. Writes are honoured in every privilege level, provided the pipeline is advancing or the debug port is the one writing. The FPU reports the flags of each retiring instruction. The block merges those flags into the word, where they stay set until software overwrites the word. When trapping is enabled and a retiring instruction raises one of the five IEEE exception flags, the block requests a floating-point exception.

For a floating-point exception, the value handed to the exception program counter is the address of the instruction after the faulting one. The handler therefore resumes past the faulting instruction and does not re-execute it forever. Any other exception reported by the pipeline for the same instruction takes priority. That exception uses its own vector and saves the faulting instruction's own address. A cause output ranks the accumulated flags so that a trap handler can report a single reason.

Top module: `fp_status_unit`

## Requirements
- R1: A write to the status word takes effect at the next clock edge only when `sprWe` is 1, `sprAddr` equals the word's address (parameter, default 0x0014), and at least one of `pipeAdvance` and `dbgAccess` is 1. The value of `supervisorMode` never affects whether a write is accepted. Writes to another address, or writes without either qualifier, leave the word unchanged.
- R2: Bit 0 of the word is the trap enable. While it is 0, no floating-point exception is requested, whatever flags arrive or are stored.
- R3: Word layout: bit 0 enable; bits 2:1 rounding mode, also driven on `roundMode`; bits 11:3 flags. Bits 31:12 always read as zero, and written values in those bits are dropped. `sprRdata` shows the word when `sprAddr` matches and shows zero otherwise.
- R4: A floating-point exception drives `excpPc` with `nextPc` and `excpVector` with 0xD00 in the cycle the request is raised.
- R5: When `instrExcp` is 1, `excpReq` is 1, `excpPc` equals `curPc`, and `excpVector` equals `instrExcpVec`. This holds even if a floating-point exception is due in the same cycle.
- R6: When `fpuRetire` is 1, the bits of `fpuFlags` are ORed into the word, with input bit k landing at word bit k+3. Input bit order: 0 overflow, 1 underflow, 2 signalling NaN, 3 quiet NaN, 4 zero, 5 inexact, 6 invalid, 7 infinity, 8 divide-by-zero. Without a write, no word bit ever goes from 1 to 0.
- R7: A floating-point exception is requested, combinationally, in a cycle in which `fpuRetire` is 1, the stored enable is 1, and `fpuFlags` has invalid, overflow, underflow, divide-by-zero or inexact set. The NaN, zero and infinity flags alone raise no exception.
- R8: `causeCode` ranks the stored flags. It gives 1 for invalid, then 2 for overflow, 3 for underflow, 4 for divide-by-zero and 5 for inexact, taking the highest-ranked flag that is set. It gives 0 (unknown) when none of these five is set.
- R9: When an accepted write and a flag merge happen in the same cycle, the word takes the written value and the merged flags are lost.
- R10: Reset (`rstN` low, asynchronous) clears the entire word, including the enable.
- R11: With only the enable set, a retiring divide of a finite nonzero value by zero reports the divide-by-zero flag. This raises a floating-point exception, and the word then reads 0x801.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sprWe | input | 1 | Special-purpose-register write strobe |
| sprAddr | input | 16 | Special-purpose-register address |
| sprWdata | input | 32 | Write data |
| pipeAdvance | input | 1 | Pipeline advances this cycle |
| dbgAccess | input | 1 | Debug port is performing the access |
| supervisorMode | input | 1 | Current privilege level; does not gate writes |
| fpuRetire | input | 1 | An FPU result retires this cycle |
| fpuFlags | input | 9 | Flags raised by the retiring FPU instruction |
| curPc | input | 32 | Address of the retiring instruction |
| nextPc | input | 32 | Address of the next instruction to execute |
| instrExcp | input | 1 | Another exception reported for the retiring instruction |
| instrExcpVec | input | 32 | Vector of that other exception |
| sprRdata | output | 32 | Read data |
| roundMode | output | 2 | Rounding-mode field |
| excpReq | output | 1 | Exception request |
| excpVector | output | 32 | Vector of the requested exception |
| excpPc | output | 32 | Value for the exception program counter |
| causeCode | output | 3 | Ranked cause of the stored flags |

## Verification
The bench writes the word from user mode, from debug with the pipeline stalled, with no qualifier, and to a wrong address. A design that still gated writes on privilege, or that ignored the debug path, would read back stale data. It retires divide-by-zero, overflow, invalid and informational-only flags, and then reads the word back. A design that cleared flags on its own, raised traps on NaN or zero flags, or still saved the faulting address would show a wrong word or a wrong `excpPc`. It also collides a write with a flag merge, retires flags with trapping disabled, and walks the cause ranking down to unknown. Mishandling any of these shows up as lost writes, spurious requests, or a wrong cause.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;

  localparam int CSR_W    = 12;
  localparam int FLAG_N   = 9;
  localparam int FLAG_LSB = 3;
  localparam int EN_BIT   = 0;
  localparam int RND_LSB  = 1;
  localparam int RND_W    = 2;

  // positions inside the incoming flag vector (word bit = index + FLAG_LSB)
  localparam int F_OVF  = 0;
  localparam int F_UNF  = 1;
  localparam int F_SNAN = 2;
  localparam int F_QNAN = 3;
  localparam int F_ZERO = 4;
  localparam int F_INX  = 5;
  localparam int F_INV  = 6;
  localparam int F_INF  = 7;
  localparam int F_DBZ  = 8;

  localparam logic [FLAG_N-1:0] TRAP_MASK =
    (FLAG_N'(1) << F_OVF) | (FLAG_N'(1) << F_UNF) | (FLAG_N'(1) << F_INX) |
    (FLAG_N'(1) << F_INV) | (FLAG_N'(1) << F_DBZ);

  typedef enum logic [2:0] {
    CAUSE_UNKNOWN   = 3'd0,
    CAUSE_INVALID   = 3'd1,
    CAUSE_OVERFLOW  = 3'd2,
    CAUSE_UNDERFLOW = 3'd3,
    CAUSE_DIVZERO   = 3'd4,
    CAUSE_INEXACT   = 3'd5
  } cause_e;

  typedef struct packed {
    logic csrSel;
    logic csrWrite;
    logic flagMerge;
    logic fpeTake;
    logic otherTake;
  } ctrl_strobe_t;

endpackage

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
  import fp_status_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] CSR_ADDR = 16'h0014
) (
  input  logic              sprWe,
  input  logic [ADDR_W-1:0] sprAddr,
  input  logic              pipeAdvance,
  input  logic              dbgAccess,
  input  logic              fpuRetire,
  input  logic [FLAG_N-1:0] fpuFlags,
  input  logic              trapEnable,
  input  logic              instrExcp,
  output ctrl_strobe_t      strb,
  output logic              excpReq
);

  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(CSR_ADDR);

  logic addrHit;
  logic writeOk;
  logic trapFlag;

  always_comb begin
    addrHit  = (sprAddr == MATCH);
    // privilege is deliberately absent from this qualifier
    writeOk  = sprWe & addrHit & (pipeAdvance | dbgAccess);
    trapFlag = |(fpuFlags & TRAP_MASK);

    strb.csrSel    = addrHit;
    strb.csrWrite  = writeOk;
    strb.flagMerge = fpuRetire & (|fpuFlags) & ~writeOk;
    strb.fpeTake   = fpuRetire & trapEnable & trapFlag;
    strb.otherTake = instrExcp;

    excpReq = strb.fpeTake | strb.otherTake;
  end

endmodule

// File: rtl/fp_status_dp.sv
module fp_status_dp
  import fp_status_pkg::*;
#(
  parameter int             DATA_W     = 32,
  parameter int             PC_W       = 32,
  parameter logic [31:0]    FPE_VECTOR = 32'h0000_0D00
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strb,
  input  logic [CSR_W-1:0]  wrData,
  input  logic [FLAG_N-1:0] fpuFlags,
  input  logic [PC_W-1:0]   curPc,
  input  logic [PC_W-1:0]   nextPc,
  input  logic [PC_W-1:0]   instrExcpVec,
  output logic [DATA_W-1:0] rdData,
  output logic              trapEnable,
  output logic [RND_W-1:0]  roundMode,
  output logic [2:0]        causeCode,
  output logic [PC_W-1:0]   excpPc,
  output logic [PC_W-1:0]   excpVector
);

  localparam int PAD_W = DATA_W - CSR_W;

  logic   [CSR_W-1:0]  csrQ;
  logic   [FLAG_N-1:0] storedFlags;
  cause_e              cause;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csrQ <= '0;
    end else if (strb.csrWrite) begin
      csrQ <= wrData;
    end else if (strb.flagMerge) begin
      csrQ <= csrQ | {fpuFlags, {FLAG_LSB{1'b0}}};
    end
  end

  always_comb begin
    storedFlags = csrQ[CSR_W-1:FLAG_LSB];
    if (storedFlags[F_INV])      cause = CAUSE_INVALID;
    else if (storedFlags[F_OVF]) cause = CAUSE_OVERFLOW;
    else if (storedFlags[F_UNF]) cause = CAUSE_UNDERFLOW;
    else if (storedFlags[F_DBZ]) cause = CAUSE_DIVZERO;
    else if (storedFlags[F_INX]) cause = CAUSE_INEXACT;
    else                         cause = CAUSE_UNKNOWN;
  end

  always_comb begin
    rdData     = strb.csrSel ? {{PAD_W{1'b0}}, csrQ} : '0;
    trapEnable = csrQ[EN_BIT];
    roundMode  = csrQ[RND_LSB +: RND_W];
    causeCode  = cause;
    // an FP trap resumes after the faulting instruction
    excpPc     = strb.otherTake ? curPc : nextPc;
    excpVector = strb.otherTake ? instrExcpVec : PC_W'(FPE_VECTOR);
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.csrWrite |=> (csrQ == $past(wrData)));  // R1

  AST_FPE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.fpeTake |-> csrQ[EN_BIT]);  // R2

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.csrWrite |=> (($past(csrQ) & ~csrQ) == '0));  // R6

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.csrWrite && (|fpuFlags)) |=> (csrQ == $past(wrData)));  // R9

endmodule

// File: rtl/fp_status_unit.sv
module fp_status_unit
  import fp_status_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DATA_W     = 32,
  parameter int          PC_W       = 32,
  parameter logic [15:0] CSR_ADDR   = 16'h0014,
  parameter logic [31:0] FPE_VECTOR = 32'h0000_0D00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sprWe,
  input  logic [ADDR_W-1:0] sprAddr,
  input  logic [DATA_W-1:0] sprWdata,
  input  logic              pipeAdvance,
  input  logic              dbgAccess,
  input  logic              supervisorMode,
  input  logic              fpuRetire,
  input  logic [8:0]        fpuFlags,
  input  logic [PC_W-1:0]   curPc,
  input  logic [PC_W-1:0]   nextPc,
  input  logic              instrExcp,
  input  logic [PC_W-1:0]   instrExcpVec,
  output logic [DATA_W-1:0] sprRdata,
  output logic [1:0]        roundMode,
  output logic              excpReq,
  output logic [PC_W-1:0]   excpVector,
  output logic [PC_W-1:0]   excpPc,
  output logic [2:0]        causeCode
);

  ctrl_strobe_t strb;
  logic         trapEnable;
  logic         unusedInputs;

  // upper write bits and privilege carry no function here
  assign unusedInputs = ^{sprWdata[DATA_W-1:CSR_W], supervisorMode};

  fp_status_ctrl #(
    .ADDR_W   (ADDR_W),
    .CSR_ADDR (CSR_ADDR)
  ) u_ctrl (
    .sprWe       (sprWe),
    .sprAddr     (sprAddr),
    .pipeAdvance (pipeAdvance),
    .dbgAccess   (dbgAccess),
    .fpuRetire   (fpuRetire),
    .fpuFlags    (fpuFlags),
    .trapEnable  (trapEnable),
    .instrExcp   (instrExcp),
    .strb        (strb),
    .excpReq     (excpReq)
  );

  fp_status_dp #(
    .DATA_W     (DATA_W),
    .PC_W       (PC_W),
    .FPE_VECTOR (FPE_VECTOR)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .wrData       (sprWdata[CSR_W-1:0]),
    .fpuFlags     (fpuFlags),
    .curPc        (curPc),
    .nextPc       (nextPc),
    .instrExcpVec (instrExcpVec),
    .rdData       (sprRdata),
    .trapEnable   (trapEnable),
    .roundMode    (roundMode),
    .causeCode    (causeCode),
    .excpPc       (excpPc),
    .excpVector   (excpVector)
  );

  AST_NO_TRAP_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (fpuRetire && !trapEnable && !instrExcp) |-> !excpReq);  // R2

  AST_FPE_SAVES_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (excpReq && !instrExcp) |-> (excpPc == nextPc && excpVector == PC_W'(FPE_VECTOR)));  // R4

  AST_OTHER_SAVES_CUR: assert property (@(posedge clk) disable iff (!rstN)
    instrExcp |-> (excpReq && excpPc == curPc && excpVector == instrExcpVec));  // R5

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    sprRdata[DATA_W-1:CSR_W] == '0);  // R3

endmodule

// File: tb/fp_status_unit_bench.sv
module fp_status_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] CSR_A = 16'h0014;

  typedef struct {
    logic [31:0] rdata;
    logic        req;
    logic [31:0] pc;
    logic [31:0] vec;
    logic [2:0]  cause;
    logic [1:0]  rnd;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sprWe = 1'b0;
  logic [15:0] sprAddr = '0;
  logic [31:0] sprWdata = '0;
  logic        pipeAdvance = 1'b0;
  logic        dbgAccess = 1'b0;
  logic        supervisorMode = 1'b0;
  logic        fpuRetire = 1'b0;
  logic [8:0]  fpuFlags = '0;
  logic [31:0] curPc = '0;
  logic [31:0] nextPc = '0;
  logic        instrExcp = 1'b0;
  logic [31:0] instrExcpVec = '0;
  logic [31:0] sprRdata;
  logic [1:0]  roundMode;
  logic        excpReq;
  logic [31:0] excpVector;
  logic [31:0] excpPc;
  logic [2:0]  causeCode;

  int   checks = 0;
  int   errors = 0;
  exp_t q[$];
  logic [11:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_status_unit u_fp_status_unit (
    .clk(clk), .rstN(rstN), .sprWe(sprWe), .sprAddr(sprAddr), .sprWdata(sprWdata),
    .pipeAdvance(pipeAdvance), .dbgAccess(dbgAccess), .supervisorMode(supervisorMode),
    .fpuRetire(fpuRetire), .fpuFlags(fpuFlags), .curPc(curPc), .nextPc(nextPc),
    .instrExcp(instrExcp), .instrExcpVec(instrExcpVec), .sprRdata(sprRdata),
    .roundMode(roundMode), .excpReq(excpReq), .excpVector(excpVector),
    .excpPc(excpPc), .causeCode(causeCode)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [2:0] causeOf(input logic [11:0] w);
    if (w[9])       return 3'd1;
    else if (w[3])  return 3'd2;
    else if (w[4])  return 3'd3;
    else if (w[11]) return 3'd4;
    else if (w[8])  return 3'd5;
    else            return 3'd0;
  endfunction

  // monitor: compares each cycle's outputs with the queued expectation
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "rdata", sprRdata, e.rdata);
        check(e.tag, "req", {31'b0, excpReq}, {31'b0, e.req});
        check(e.tag, "cause", {29'b0, causeCode}, {29'b0, e.cause});
        check(e.tag, "rnd", {30'b0, roundMode}, {30'b0, e.rnd});
        if (e.req) begin
          check(e.tag, "pc", excpPc, e.pc);
          check(e.tag, "vec", excpVector, e.vec);
        end
      end
    end
  end

  // driver: applies one cycle of stimulus and queues what must be seen
  task automatic step(input logic we, input logic [15:0] addr, input logic [31:0] wd,
                      input logic adv, input logic dbg, input logic sup,
                      input logic ret, input logic [8:0] fl,
                      input logic iex, input logic [31:0] ivec, input string tag);
    exp_t e;
    logic fpe;
    logic trapBits;
    @(negedge clk);
    sprWe = we; sprAddr = addr; sprWdata = wd; pipeAdvance = adv; dbgAccess = dbg;
    supervisorMode = sup; fpuRetire = ret; fpuFlags = fl; instrExcp = iex;
    instrExcpVec = ivec;
    curPc = curPc + 32'h40; nextPc = curPc + 32'h4;
    // trap flags: overflow 0, underflow 1, inexact 5, invalid 6, div-by-zero 8
    trapBits = fl[0] | fl[1] | fl[5] | fl[6] | fl[8];
    fpe = ret & model[0] & trapBits;
    e.rdata = (addr == CSR_A) ? {20'b0, model} : 32'h0;
    e.req   = fpe | iex;
    e.pc    = iex ? curPc : nextPc;
    e.vec   = iex ? ivec : 32'h0000_0D00;
    e.cause = causeOf(model);
    e.rnd   = model[2:1];
    e.tag   = tag;
    q.push_back(e);
    if (we && addr == CSR_A && (adv || dbg)) model = wd[11:0];
    else if (ret) model = model | {fl, 3'b000};
  endtask

  task automatic rd(input string tag);
    step(1'b0, CSR_A, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h0, 1'b0, 32'h0, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sprWe = 1'b0; fpuRetire = 1'b0; instrExcp = 1'b0;
    model = '0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    rd("R10 reset word zero");
    // user-mode write, pipeline advancing: enable + rounding mode 2
    step(1'b1, CSR_A, 32'h0000_0005, 1'b1, 1'b0, 1'b0, 1'b0, 9'h0, 1'b0, 32'h0, "R1 user write");
    rd("R3 rounding field");
    // no qualifier: ignored
    step(1'b1, CSR_A, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 9'h0, 1'b0, 32'h0, "R1 unqualified");
    rd("R1 unqualified ignored");
    // debug path with stalled pipe, upper bits dropped
    step(1'b1, CSR_A, 32'hFFFF_F001, 1'b0, 1'b1, 1'b0, 1'b0, 9'h0, 1'b0, 32'h0, "R1 debug write");
    rd("R3 upper bits zero");
    // wrong address
    step(1'b1, 16'h0011, 32'h0000_0006, 1'b1, 1'b0, 1'b1, 1'b0, 9'h0, 1'b0, 32'h0, "R1 R3 other addr");
    rd("R1 other addr ignored");
    // divide by zero
    step(1'b0, CSR_A, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h100, 1'b0, 32'h0, "R4 R7 R11 dbz trap");
    rd("R11 reads 801 R8");
    // informational flag only: zero
    step(1'b0, CSR_A, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h010, 1'b0, 32'h0, "R7 zero flag no trap");
    rd("R6 sticky merge");
    // other exception with overflow flag
    step(1'b0, CSR_A, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h001, 1'b1, 32'h0000_0700, "R5 other wins");
    rd("R8 overflow over dbz");
    step(1'b0, CSR_A, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h040, 1'b0, 32'h0, "R7 invalid trap");
    rd("R8 invalid first");
    // write collides with merge
    step(1'b1, CSR_A, 32'h0000_0001, 1'b1, 1'b0, 1'b0, 1'b1, 9'h020, 1'b0, 32'h0, "R9 collide");
    rd("R9 write wins");
    // disable, then retire invalid
    step(1'b1, CSR_A, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h0, 1'b0, 32'h0, "R2 disable");
    step(1'b0, CSR_A, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h040, 1'b0, 32'h0, "R2 no trap disabled");
    rd("R2 R6 flag kept");
    step(1'b1, CSR_A, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h0, 1'b0, 32'h0, "R8 clear");
    rd("R8 unknown");
    step(1'b0, CSR_A, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h022, 1'b0, 32'h0, "R2 unf inx disabled");
    rd("R8 underflow over inexact");
    step(1'b1, CSR_A, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 9'h0, 1'b0, 32'h0, "R8 clear2");
    step(1'b0, CSR_A, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1, 9'h020, 1'b0, 32'h0, "R6 inexact");
    rd("R8 inexact only");
    step(1'b1, CSR_A, 32'h0000_0003, 1'b1, 1'b0, 1'b1, 1'b0, 9'h0, 1'b0, 32'h0, "R1 supervisor write");
    step(1'b0, CSR_A, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0, 1'b1, 32'h0000_0200, "R5 no flags");
    rd("R3 rnd 1");
    doReset();
    rd("R10 reset clears enable");
    @(negedge clk);
    #(CLK_PERIOD);
    finish();
  end

endmodule